// File: doc/BRIEF.md
# Zero-Biased Fast-Track Voter

This block merges the outputs of several redundant copies of one logic function into a single bit. The copies may differ in how much redundancy they carry; for example, a triplicated group plus a single copy gives four lines, and a triplicated, a duplicated and a single group give six. Every line is precharged high before an evaluation window. During the window a line may only fall to 0. A wrong 0 is far less likely than a slow one, so the vote is biased toward 0. As soon as the number of lines that have fallen reaches a runtime threshold k, the block commits a 0 to the next stage. It does not wait for the slower copies.

If the window closes before k lines have fallen, the block commits a 1 at the close. Each decision raises a valid flag that holds until the next window opens. A zero committed while the window is open also raises a one-cycle early-decision pulse. The lines are a flat vector, and the grouping into redundant copies is set by how the lines are wired and by the choice of k.

Top module: `ftv_voter`

## Requirements
- R1: After reset, `vote_out` is 1, `vote_valid` is 0 and `early_flag` is 0.
- R2: A line counts as a zero vote only if it was 1 at the previous clock edge and is 0 at an edge where `eval_win` is 1. A line that is already 0 when the window opens never counts during that window.
- R3: A line that has fallen stays counted for the rest of the window, even if it returns to 1.
- R4: The k-th counted fall is sampled at some clock edge. From the cycle that follows that edge, `vote_out` is 0 and `vote_valid` is 1, and `early_flag` is 1 in that same cycle.
- R5: `early_flag` is high for exactly one cycle per committed zero.
- R6: A committed zero holds `vote_out`=0 and `vote_valid`=1 until the next window opens. Later line changes and the window close do not alter it.
- R7: Suppose `eval_win` is first sampled 0 and fewer than k lines have fallen. Then in the following cycle `vote_out` is 1, `vote_valid` is 1 and `early_flag` is 0.
- R8: The effective threshold is 1 when `thresh` is 0, and it is N_LINES when `thresh` exceeds N_LINES. Otherwise it equals `thresh`.
- R9: If the threshold is reached at the last edge at which `eval_win` is 1, the zero decision wins: the outcome is as in R4, not R7.
- R10: When a window opens without an immediate commit, `vote_valid` is 0 in the cycle after the first edge at which `eval_win` is sampled 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_win | input | 1 | High during the evaluation window, low during precharge |
| lines | input | N_LINES | Replica outputs, precharged high |
| thresh | input | TH_W | Zero-count threshold k |
| vote_out | output | 1 | Voted bit |
| vote_valid | output | 1 | Decision valid, held until the next window opens |
| early_flag | output | 1 | One-cycle pulse when a zero is committed |

## Verification
The fast-track zero commit and the window-close default-one decision can fall due in the same cycle. This happens when the k-th fall arrives on the final cycle of the window. The bench provokes it by placing that arrival on the last window cycle, with `eval_win` dropping at the very next edge. It then judges that the result is a zero with the early pulse, and that the close does not overwrite it with a 1 one cycle later. A second collision is a commit in the very first window cycle, where the window opening must not clear the fresh decision.

// File: rtl/ftv_pkg.sv
package ftv_pkg;
  typedef enum logic [1:0] {
    PH_PRE  = 2'd0,
    PH_EVAL = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/ftv_line_capture.sv
module ftv_line_capture #(
  parameter int N_LINES = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win,
  input  logic [N_LINES-1:0] lines,
  output logic [N_LINES-1:0] votes
);
  logic [N_LINES-1:0] line_q;
  logic [N_LINES-1:0] seen_q;
  logic [N_LINES-1:0] fall;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    // a vote is a high-to-low step inside the window
    assign fall[g]  = win & line_q[g] & ~lines[g];
    assign votes[g] = seen_q[g] | fall[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        line_q[g] <= 1'b1;
        seen_q[g] <= 1'b0;
      end else begin
        line_q[g] <= lines[g];
        seen_q[g] <= win ? votes[g] : 1'b0;
      end
    end
  end
endmodule

// File: rtl/ftv_zero_count.sv
module ftv_zero_count #(
  parameter int N_LINES = 6,
  parameter int TH_W    = 3
) (
  input  logic [N_LINES-1:0] votes,
  output logic [TH_W-1:0]    cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N_LINES; i++) begin
      cnt = cnt + TH_W'(votes[i]);
    end
  end
endmodule

// File: rtl/ftv_decide.sv
module ftv_decide
  import ftv_pkg::*;
#(
  parameter int N_LINES = 6,
  parameter int TH_W    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            win,
  input  logic [TH_W-1:0] cnt,
  input  logic [TH_W-1:0] thresh,
  output logic            vote_o,
  output logic            valid_o,
  output logic            early_o
);
  localparam logic [TH_W-1:0] K_MAX = TH_W'(N_LINES);

  phase_t          ph_q;
  logic [TH_W-1:0] keff;
  logic            hit;

  always_comb begin
    if (thresh == '0)        keff = TH_W'(1);
    else if (thresh > K_MAX) keff = K_MAX;
    else                     keff = thresh;
  end

  assign hit = (cnt >= keff);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_PRE;
      vote_o  <= 1'b1;
      valid_o <= 1'b0;
      early_o <= 1'b0;
    end else begin
      early_o <= 1'b0;
      if (!win) begin
        if (ph_q == PH_EVAL) begin
          vote_o  <= 1'b1;
          valid_o <= 1'b1;
        end
        ph_q <= PH_PRE;
      end else if (ph_q != PH_DONE) begin
        if (hit) begin
          vote_o  <= 1'b0;
          valid_o <= 1'b1;
          early_o <= 1'b1;
          ph_q    <= PH_DONE;
        end else begin
          if (ph_q == PH_PRE) begin
            vote_o  <= 1'b1;
            valid_o <= 1'b0;
          end
          ph_q <= PH_EVAL;
        end
      end
    end
  end
endmodule

// File: rtl/ftv_voter.sv
module ftv_voter #(
  parameter int N_LINES = 6,
  parameter int TH_W    = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               eval_win,
  input  logic [N_LINES-1:0] lines,
  input  logic [TH_W-1:0]    thresh,
  output logic               vote_out,
  output logic               vote_valid,
  output logic               early_flag
);
  logic [N_LINES-1:0] votes;
  logic [TH_W-1:0]    zcnt;

  ftv_line_capture #(.N_LINES(N_LINES)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .win   (eval_win),
    .lines (lines),
    .votes (votes)
  );

  ftv_zero_count #(.N_LINES(N_LINES), .TH_W(TH_W)) u_cnt (
    .votes (votes),
    .cnt   (zcnt)
  );

  ftv_decide #(.N_LINES(N_LINES), .TH_W(TH_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .win     (eval_win),
    .cnt     (zcnt),
    .thresh  (thresh),
    .vote_o  (vote_out),
    .valid_o (vote_valid),
    .early_o (early_flag)
  );
endmodule

// File: rtl/ftv_voter_chk.sv
module ftv_voter_chk (
  input logic clk,
  input logic rst,
  input logic eval_win,
  input logic vote_out,
  input logic vote_valid,
  input logic early_flag
);
  logic rst_seen;

  always_ff @(posedge clk) rst_seen <= rst;

  // R1
  always @(negedge clk) begin
    if (rst_seen) begin
      reset_state_chk: assert (vote_out && !vote_valid && !early_flag);
    end
  end

  // R5
  early_single_chk: assert property (@(posedge clk) disable iff (rst)
    early_flag |=> !early_flag);

  // R4
  early_zero_chk: assert property (@(posedge clk) disable iff (rst)
    early_flag |-> (!vote_out && vote_valid));

  // R6
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vote_valid && !vote_out && eval_win && $past(eval_win)) |=> (vote_valid && !vote_out));

  // R7
  close_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!eval_win && $past(eval_win)) |=> vote_valid);
endmodule

bind ftv_voter ftv_voter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .eval_win   (eval_win),
  .vote_out   (vote_out),
  .vote_valid (vote_valid),
  .early_flag (early_flag)
);

// File: tb/ftv_voter_tb.sv
module ftv_voter_tb;
  localparam int N = 6;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          eval_win;
  logic [N-1:0]  lines;
  logic [TW-1:0] thresh;
  logic          vote_out, vote_valid, early_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int arr [N];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  ftv_voter #(.N_LINES(N)) u_dut (
    .clk(clk), .rst(rst), .eval_win(eval_win), .lines(lines),
    .thresh(thresh), .vote_out(vote_out), .vote_valid(vote_valid),
    .early_flag(early_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: {vote,valid,early} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] obs();
    return {vote_out, vote_valid, early_flag};
  endfunction

  // drives one precharge + window and checks against the counting model
  task automatic run_window(input int k, input int wlen, input bit bounce,
                            input logic [N-1:0] stuck, input string tag);
    int keff = (k == 0) ? 1 : ((k > N) ? N : k);
    int commit = -1;
    for (int t = 0; t < wlen; t++) begin
      int c = 0;
      for (int i = 0; i < N; i++)
        if (!stuck[i] && arr[i] >= 0 && arr[i] <= t) c++;
      if (c >= keff && commit < 0) commit = t;
    end
    @(negedge clk);
    eval_win = 1'b0; lines = ~stuck; thresh = TW'(k);
    repeat (2) @(negedge clk);
    for (int t = 0; t <= wlen + 1; t++) begin
      if (t > 0) @(negedge clk);
      if (t == 1 && commit != 0)
        chk(vote_valid == 1'b0, {"R10 ", tag}, obs(), {vote_out, 2'b00});
      if (commit >= 0 && t == commit + 1)
        chk(obs() == 3'b011, {"R4 ", tag}, obs(), 3'b011);
      if (commit >= 0 && t == commit + 2)
        chk(obs() == 3'b010, {"R5 ", tag}, obs(), 3'b010);
      if (commit >= 0 && t == wlen + 1)
        chk(obs() == 3'b010, {"R6 ", tag}, obs(), 3'b010);
      if (commit < 0 && t == wlen + 1)
        chk(obs() == 3'b110, {"R7 ", tag}, obs(), 3'b110);
      if (t < wlen) begin
        eval_win = 1'b1;
        for (int i = 0; i < N; i++)
          lines[i] = stuck[i] ? 1'b0 :
                     ((arr[i] >= 0 && (bounce ? (t == arr[i]) : (t >= arr[i]))) ? 1'b0 : 1'b1);
      end else begin
        eval_win = 1'b0;
        lines = '1;
      end
    end
  endtask

  task automatic set_arr(input int a0, a1, a2, a3, a4, a5);
    arr[0] = a0; arr[1] = a1; arr[2] = a2; arr[3] = a3; arr[4] = a4; arr[5] = a5;
  endtask

  task automatic t_reset();
    rst = 1'b1; eval_win = 1'b0; lines = '1; thresh = '0;
    repeat (3) @(negedge clk);
    chk(obs() == 3'b100, "R1 reset state", obs(), 3'b100);
    rst = 1'b0;
  endtask

  task automatic t_four_lines();   // 3-way group + single, k=2
    set_arr(3, 5, -1, 1, -1, -1);
    run_window(2, 8, 1'b0, '0, "four lines k=2");
  endtask

  task automatic t_six_lines();    // 3w+2w+w, k=1
    set_arr(-1, 4, -1, 2, 6, -1);
    run_window(1, 8, 1'b0, '0, "six lines k=1");
  endtask

  task automatic t_no_threshold();
    set_arr(2, -1, 5, -1, -1, -1);
    run_window(3, 7, 1'b0, '0, "below threshold");
  endtask

  task automatic t_zero_k();       // R8
    set_arr(-1, -1, 3, -1, -1, -1);
    run_window(0, 6, 1'b0, '0, "R8 k=0 as 1");
  endtask

  task automatic t_big_k();        // R8
    set_arr(0, 1, 1, 2, 3, 4);
    run_window(7, 7, 1'b0, '0, "R8 k clamp to N");
  endtask

  task automatic t_last_cycle();   // R9 collision
    set_arr(1, 4, -1, -1, -1, -1);
    run_window(2, 5, 1'b0, '0, "R9 last-cycle commit");
  endtask

  task automatic t_bounce();       // R3
    set_arr(1, 3, 5, -1, -1, -1);
    run_window(3, 8, 1'b1, '0, "R3 pulsed lines stay counted");
  endtask

  task automatic t_stuck();        // R2
    set_arr(-1, -1, 4, -1, -1, -1);
    run_window(2, 7, 1'b0, 6'b000011, "R2 pre-low lines ignored");
  endtask

  task automatic t_after_commit(); // R6
    set_arr(1, 3, 4, 5, 5, 6);
    run_window(1, 8, 1'b1, '0, "R6 later changes ignored");
  endtask

  task automatic t_same_cycle();
    set_arr(3, 3, 3, -1, -1, -1);
    run_window(3, 6, 1'b0, '0, "R4 simultaneous arrivals");
  endtask

  task automatic t_first_cycle();
    set_arr(-1, 0, -1, -1, -1, -1);
    run_window(1, 5, 1'b0, '0, "R4 commit at window open");
  endtask

  task automatic t_random();
    for (int w = 0; w < 6; w++) begin
      int kk;
      for (int i = 0; i < N; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        arr[i] = int'(lfsr % 12) - 2;
        if (arr[i] < 0) arr[i] = -1;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      kk = int'(lfsr % 8);
      run_window(kk, 8, w[0], '0, "random arrivals");
    end
  endtask

  initial begin
    t_reset();
    t_four_lines();
    t_six_lines();
    t_no_threshold();
    t_zero_k();
    t_big_k();
    t_last_cycle();
    t_bounce();
    t_stuck();
    t_after_commit();
    t_same_cycle();
    t_first_cycle();
    t_random();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule